// File: doc/BRIEF.md
# Filtered serial command register file

This block is the control front end of a knock-detection signal processor. A host writes 8-bit command words over a mode-0 style serial link: the select line is active low, data is taken on the falling edge of the serial clock, and the most significant bit comes first. The leading bits of each word are a prefix of two or three bits that names one of five control registers. The remaining bits are the value written to that register. The five registers hold a band-pass filter frequency code, a gain code, an integrator time-constant code, a test/channel word and a prescaler/output-enable word. Each register is presented on parallel outputs for the analog chain.

A framing filter checks every frame and discards any frame that is not clean. A clean frame starts with the serial clock low when select falls, has exactly eight low-high-low clock pulses, and ends with the clock low when select rises. A clean word reaches its register only when select rises. All serial inputs are brought into a fast system clock through a two-stage synchroniser. The serial output is a data bit plus an output enable. In normal operation it returns the last accepted word. When the test input is low it becomes a diagnostic port. In that mode it can echo the data input, pass a comparator bit, or shift out the contents of any register.

Top module: `cmdreg_top`

## Requirements
- R1: After reset every register output is zero, which selects channel 0. The first frame after reset returns 0x00 on the serial output. With test high, the output enable is 0 while select is high and 1 while select is low.
- R2: The eight data bits are taken on the eight falling edges of the serial clock, most significant bit first.
- R3: Decoding uses bits 7:6 and, for prefix 11, bit 5. Prefix 00 writes bits 5:0 to the frequency code. Prefix 10 writes bits 5:0 to the gain code. Prefix 01 writes bits 4:1 to the prescaler code and bit 0 to the high-impedance flag, and bit 5 is ignored. Prefix 110 writes bits 4:0 to the time-constant code. Prefix 111 writes bit 0 to the channel select and bits 4:1 to the diagnostic select. A frame writes exactly one register.
- R4: A frame changes no register and is discarded in each of these cases: the serial clock is high when select falls, fewer or more than eight falling clock edges occur while select is low, or the clock is high when select rises.
- R5: A clean word takes effect only when select rises. After eight pulses, with select still low, every register keeps its old value.
- R6: With test high, the output enable is 0 whenever select is high. It is also 0 while select is low if the high-impedance flag is 1. It is 1 while select is low if the flag is 0.
- R7: With test high, each frame shifts out the last accepted word, most significant bit first. A new bit appears after each rising serial clock edge, so the host can sample it on the following falling edge.
- R8: With test low, the output enable is 1 whatever the select line and the high-impedance flag. The diagnostic select picks the output source. Value 0, and values 7 to 15, echo the data input. Value 1 passes the comparator bit. Values 2 to 6 shift out, as in R7, the full command word that would recreate the frequency, gain, time-constant, test or prescaler register respectively; prescaler bit 5 reads as 0.
- R9: With test high, the diagnostic select has no effect on the serial output. R6 and R7 apply unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock, idles low |
| spi_csn_i | input | 1 | Active-low select |
| spi_sdi_i | input | 1 | Serial data in |
| test_n_i | input | 1 | Low selects diagnostic mode |
| cmp_bit_i | input | 1 | Comparator bit that can be observed in diagnostic mode |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Output enable for the serial data pad |
| freq_code_o | output | 6 | Band-pass frequency code |
| gain_code_o | output | 6 | Gain code |
| tc_code_o | output | 5 | Integrator time-constant code |
| chan_sel_o | output | 1 | Input channel select |
| diag_sel_o | output | 4 | Diagnostic source select |
| presc_code_o | output | 4 | Clock prescaler code |

## Verification
Several properties are checked on every cycle by assertions. The framing counter never leaves its saturating range. A commit is never seen without a select period just before it. No register moves unless a commit strobe is present, and at most one register changes per strobe. The shift-out bit moves only on a load or a rising clock edge. Whether a rejected frame truly leaves every register alone, whether the decoded prefixes land in the right fields, and what each diagnostic source returns can only be shown by the bench's sweeps and crafted malformed frames, which it observes at the ports.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam int WORD_W  = 8;
  localparam int FREQ_W  = 6;
  localparam int GAIN_W  = 6;
  localparam int TC_W    = 5;
  localparam int TEST_W  = 5;
  localparam int PRESC_W = 4;
  localparam int DSEL_W  = TEST_W - 1;
  localparam int N_DEST  = 5;

  typedef enum logic [2:0] {
    DST_FREQ  = 3'd0,
    DST_GAIN  = 3'd1,
    DST_TC    = 3'd2,
    DST_TEST  = 3'd3,
    DST_PRESC = 3'd4
  } dest_e;

  typedef struct packed {
    logic [FREQ_W-1:0]  freq;
    logic [GAIN_W-1:0]  gain;
    logic [TC_W-1:0]    tc;
    logic [TEST_W-1:0]  test;
    logic [PRESC_W-1:0] presc;
    logic               hiz;
  } regs_t;

  // Prefix decode: two bits, extended by a third when the first two are 11.
  function automatic dest_e word_dest(input logic [WORD_W-1:0] w);
    dest_e d;
    case (w[WORD_W-1 -: 2])
      2'b00:   d = DST_FREQ;
      2'b10:   d = DST_GAIN;
      2'b01:   d = DST_PRESC;
      default: d = w[WORD_W-3] ? DST_TEST : DST_TC;
    endcase
    return d;
  endfunction

  // Rebuilds the command word that would recreate a register's contents.
  function automatic logic [WORD_W-1:0] word_of(input regs_t r, input dest_e d);
    logic [WORD_W-1:0] w;
    case (d)
      DST_FREQ:  w = {2'b00, r.freq};
      DST_GAIN:  w = {2'b10, r.gain};
      DST_TC:    w = {3'b110, r.tc};
      DST_TEST:  w = {3'b111, r.test};
      default:   w = {2'b01, 1'b0, r.presc, r.hiz};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cmdreg_sync.sv
module cmdreg_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmdreg_frame.sv
module cmdreg_frame import cmdreg_pkg::*; #(
  parameter int FW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          csn_s,
  input  logic          sdi_s,
  output logic          cs_fall_e,
  output logic          sck_rise_e,
  output logic          commit_stb,
  output logic [FW-1:0] commit_word
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);

  logic             sck_d, csn_d;
  logic             sck_fall_e, cs_rise_e;
  logic [CNT_W-1:0] fall_cnt;
  logic             start_ok;
  logic [FW-1:0]    rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
    end
  end

  assign sck_rise_e = sck_s & ~sck_d;
  assign sck_fall_e = ~sck_s & sck_d;
  assign cs_fall_e  = ~csn_s & csn_d;
  assign cs_rise_e  = csn_s & ~csn_d;

  // Filter state: clock level at select fall, saturating count of falls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ok <= 1'b0;
      fall_cnt <= '0;
      rx_sh    <= '0;
    end else if (cs_fall_e) begin
      start_ok <= ~sck_s;
      fall_cnt <= '0;
    end else if (!csn_s && sck_fall_e) begin
      rx_sh <= {rx_sh[FW-2:0], sdi_s};
      if (fall_cnt != CNT_MAX) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assign commit_stb  = cs_rise_e && start_ok && (fall_cnt == CNT_FULL) && !sck_s;
  assign commit_word = rx_sh;

  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CNT_MAX);
  a_r5_commit_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(!csn_s));
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank import cmdreg_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_stb,
  input  logic [WORD_W-1:0] commit_word,
  output regs_t             regs_o,
  output logic [WORD_W-1:0] last_word_o
);
  regs_t             regs_q;
  logic [WORD_W-1:0] last_q;
  dest_e             dest;
  logic [N_DEST-1:0] wr_vec;

  assign dest = word_dest(commit_word);

  for (genvar i = 0; i < N_DEST; i++) begin : g_wr
    assign wr_vec[i] = commit_stb && (dest == dest_e'(3'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
      last_q <= '0;
    end else begin
      if (wr_vec[DST_FREQ])  regs_q.freq  <= commit_word[FREQ_W-1:0];
      if (wr_vec[DST_GAIN])  regs_q.gain  <= commit_word[GAIN_W-1:0];
      if (wr_vec[DST_TC])    regs_q.tc    <= commit_word[TC_W-1:0];
      if (wr_vec[DST_TEST])  regs_q.test  <= commit_word[TEST_W-1:0];
      if (wr_vec[DST_PRESC]) begin
        regs_q.presc <= commit_word[PRESC_W:1];
        regs_q.hiz   <= commit_word[0];
      end
      if (commit_stb) last_q <= commit_word;
    end
  end

  assign regs_o      = regs_q;
  assign last_word_o = last_q;

  a_r3_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_stb |=> $stable(regs_q));
  a_r3_one_reg_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!$stable(regs_q.freq), !$stable(regs_q.gain), !$stable(regs_q.tc),
              !$stable(regs_q.test), !$stable({regs_q.presc, regs_q.hiz})}));
endmodule

// File: rtl/cmdreg_sout.sv
module cmdreg_sout import cmdreg_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              test_n_s,
  input  logic              cmp_s,
  input  logic              cs_fall_e,
  input  logic              sck_rise_e,
  input  regs_t             regs_i,
  input  logic [WORD_W-1:0] last_word_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic              diag;
  logic [DSEL_W-1:0] sel;
  logic              rd_reg;
  logic [2:0]        rd_idx;
  logic [WORD_W-1:0] load_word;
  logic [WORD_W-1:0] tx_sh;
  logic              tx_bit;

  assign diag   = ~test_n_s;
  assign sel    = regs_i.test[TEST_W-1:1];
  assign rd_reg = diag && (sel >= DSEL_W'(2)) && (sel <= DSEL_W'(6));
  assign rd_idx = 3'(sel - DSEL_W'(2));
  assign load_word = rd_reg ? word_of(regs_i, dest_e'(rd_idx)) : last_word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_bit <= 1'b0;
    end else if (cs_fall_e) begin
      tx_sh  <= load_word;
      tx_bit <= load_word[WORD_W-1];
    end else if (sck_rise_e && !csn_s) begin
      tx_bit <= tx_sh[WORD_W-1];
      tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  always_comb begin
    sdo_o = tx_bit;
    if (diag && !rd_reg) sdo_o = (sel == DSEL_W'(1)) ? cmp_s : sdi_s;
  end

  assign sdo_oe_o = diag | (~csn_s & ~regs_i.hiz);

  a_r7_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise_e && !cs_fall_e) |=> $stable(tx_bit));
  a_r8_diag_drives: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_n_s) |=> sdo_oe_o);
  a_r6_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n_s && csn_s && $past(csn_s) && $past(test_n_s)) |-> !sdo_oe_o);
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top import cmdreg_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck_i,
  input  logic               spi_csn_i,
  input  logic               spi_sdi_i,
  input  logic               test_n_i,
  input  logic               cmp_bit_i,
  output logic               spi_sdo_o,
  output logic               spi_sdo_oe_o,
  output logic [FREQ_W-1:0]  freq_code_o,
  output logic [GAIN_W-1:0]  gain_code_o,
  output logic [TC_W-1:0]    tc_code_o,
  output logic               chan_sel_o,
  output logic [DSEL_W-1:0]  diag_sel_o,
  output logic [PRESC_W-1:0] presc_code_o
);
  localparam int IN_W = 5;

  logic [IN_W-1:0]   sync_q;
  logic              sck_s, csn_s, sdi_s, test_n_s, cmp_s;
  logic              cs_fall_e, sck_rise_e, commit_stb;
  logic [WORD_W-1:0] commit_word, last_word;
  regs_t             regs;

  cmdreg_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b01010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({spi_sck_i, spi_csn_i, spi_sdi_i, test_n_i, cmp_bit_i}),
    .q_o(sync_q)
  );
  assign {sck_s, csn_s, sdi_s, test_n_s, cmp_s} = sync_q;

  cmdreg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .cs_fall_e(cs_fall_e), .sck_rise_e(sck_rise_e),
    .commit_stb(commit_stb), .commit_word(commit_word)
  );

  cmdreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit_stb(commit_stb), .commit_word(commit_word),
    .regs_o(regs), .last_word_o(last_word)
  );

  cmdreg_sout u_sout (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sdi_s(sdi_s), .test_n_s(test_n_s),
    .cmp_s(cmp_s), .cs_fall_e(cs_fall_e), .sck_rise_e(sck_rise_e),
    .regs_i(regs), .last_word_i(last_word),
    .sdo_o(spi_sdo_o), .sdo_oe_o(spi_sdo_oe_o)
  );

  assign freq_code_o  = regs.freq;
  assign gain_code_o  = regs.gain;
  assign tc_code_o    = regs.tc;
  assign chan_sel_o   = regs.test[0];
  assign diag_sel_o   = regs.test[TEST_W-1:1];
  assign presc_code_o = regs.presc;
endmodule

// File: tb/cmdreg_top_bench.sv
module cmdreg_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0, test_n = 1'b1, cmp = 1'b0;
  logic sdo, sdo_oe;
  logic [5:0] freq, gain;
  logic [4:0] tc;
  logic chan;
  logic [3:0] dsel, presc;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  int m_freq = 0, m_gain = 0, m_tc = 0, m_test = 0, m_presc = 0, m_hiz = 0, m_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdreg_top u_cmdreg_top (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_csn_i(csn), .spi_sdi_i(sdi),
    .test_n_i(test_n), .cmp_bit_i(cmp), .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
    .freq_code_o(freq), .gain_code_o(gain), .tc_code_o(tc), .chan_sel_o(chan),
    .diag_sel_o(dsel), .presc_code_o(presc)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_apply(input int w);
    int top2;
    top2 = w / 64;
    if (top2 == 0) m_freq = w % 64;
    else if (top2 == 2) m_gain = w % 64;
    else if (top2 == 1) begin m_presc = (w / 2) % 16; m_hiz = w % 2; end
    else if ((w / 32) % 2 == 1) m_test = w % 32;
    else m_tc = w % 32;
    m_last = w;
  endfunction

  task automatic frame(input logic [7:0] w, input int npulse, input bit hi_fall,
                       input bit hi_rise, output logic [7:0] cap, output logic oe_all);
    cap = '0;
    oe_all = 1'b1;
    if (hi_fall) begin sck = 1'b1; wait_clk(H); end
    csn = 1'b0; wait_clk(H);
    if (hi_fall) begin sck = 1'b0; wait_clk(H); end
    for (int i = 0; i < npulse; i++) begin
      sdi = (i < 8) ? w[7-i] : 1'b0;
      sck = 1'b1; wait_clk(H);
      cap = {cap[6:0], sdo};
      oe_all = oe_all & sdo_oe;
      sck = 1'b0; wait_clk(H);
    end
    if (hi_rise) begin sck = 1'b1; wait_clk(H); end
    csn = 1'b1; wait_clk(H);
    if (hi_rise) sck = 1'b0;
    wait_clk(2*H);
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " freq"}, int'(freq), m_freq);
    chk({tag, " gain"}, int'(gain), m_gain);
    chk({tag, " tc"}, int'(tc), m_tc);
    chk({tag, " chan"}, int'(chan), m_test % 2);
    chk({tag, " dsel"}, int'(dsel), m_test / 2);
    chk({tag, " presc"}, int'(presc), m_presc);
  endtask

  // Good frame in normal mode: checks readback of the previous word and the write.
  task automatic good_write(input int w, input string tag);
    logic [7:0] cap;
    logic oe;
    int prev, prev_hiz;
    prev = m_last;
    prev_hiz = m_hiz;
    frame(8'(w), 8, 0, 0, cap, oe);
    model_apply(w);
    if (prev_hiz == 0) begin
      chk({tag, " R7 readback"}, int'(cap), prev);
      chk({tag, " R6 oe on"}, int'(oe), 1);
    end else begin
      chk({tag, " R6 oe off by flag"}, int'(oe), 0);
    end
    check_regs({tag, " R2 R3"});
  endtask

  initial begin
    wait_clk(WATCHDOG);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    logic oe;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check_regs("R1 reset");
    chk("R1 oe deselected", int'(sdo_oe), 0);
    csn = 1'b0; wait_clk(5);
    chk("R1 oe selected", int'(sdo_oe), 1);
    csn = 1'b1; wait_clk(5);

    // R2/R3/R7 sweeps over every value of every register
    for (int v = 0; v < 64; v++) good_write(v, "sweep freq");
    for (int v = 0; v < 64; v++) good_write(128 + v, "sweep gain");
    for (int v = 0; v < 32; v++) good_write(192 + v, "sweep tc");
    // R9: diagnostic select values written while test is high leave R6/R7 in force
    for (int v = 0; v < 32; v++) good_write(224 + v, "R9 sweep test");
    for (int v = 0; v < 64; v++) good_write(64 + v, "R3 sweep presc");
    good_write(64, "presc enable");

    // R4 malformed frames
    good_write(8'h15, "R4 base");
    frame(8'h2A, 7, 0, 0, cap, oe);
    check_regs("R4 seven pulses");
    frame(8'h2A, 9, 0, 0, cap, oe);
    check_regs("R4 nine pulses");
    frame(8'h2A, 8, 1, 0, cap, oe);
    check_regs("R4 sck high at select fall");
    frame(8'h2A, 8, 0, 1, cap, oe);
    check_regs("R4 sck high at select rise");

    // R5 commit only at select rise
    csn = 1'b0; wait_clk(H);
    for (int i = 0; i < 8; i++) begin
      sdi = 1'(8'h2A >> (7 - i));
      sck = 1'b1; wait_clk(H);
      sck = 1'b0; wait_clk(H);
    end
    wait_clk(4*H);
    chk("R5 no write before select rise", int'(freq), 8'h15);
    csn = 1'b1; wait_clk(2*H);
    model_apply(8'h2A);
    chk("R5 write at select rise", int'(freq), 8'h2A);

    // R6 high-impedance flag with select low
    good_write(64 + 8'h0B, "R6 set flag");
    csn = 1'b0; wait_clk(5);
    chk("R6 flag forces oe low", int'(sdo_oe), 0);
    csn = 1'b1; wait_clk(5);
    good_write(64 + 8'h0A, "R6 clear flag");
    csn = 1'b0; wait_clk(5);
    chk("R6 oe with flag clear", int'(sdo_oe), 1);
    csn = 1'b1; wait_clk(5);
    good_write(64 + 8'h01, "R8 prep flag");

    // R8 diagnostic sources
    good_write(8'hE0, "R8 sel0");
    test_n = 1'b0; wait_clk(5);
    chk("R8 oe forced", int'(sdo_oe), 1);
    sdi = 1'b1; wait_clk(4);
    chk("R8 echo si=1", int'(sdo), 1);
    sdi = 1'b0; wait_clk(4);
    chk("R8 echo si=0", int'(sdo), 0);
    frame(8'hE2, 8, 0, 0, cap, oe);
    model_apply(8'hE2);
    cmp = 1'b1; wait_clk(4);
    chk("R8 comparator 1", int'(sdo), 1);
    cmp = 1'b0; wait_clk(4);
    chk("R8 comparator 0", int'(sdo), 0);
    for (int k = 2; k <= 6; k++) begin
      int w, exp;
      w = 224 + 2 * k;
      frame(8'(w), 8, 0, 0, cap, oe);
      model_apply(w);
      frame(8'(w), 8, 0, 0, cap, oe);
      case (k)
        2: exp = m_freq;
        3: exp = 128 + m_gain;
        4: exp = 192 + m_tc;
        5: exp = 224 + m_test;
        default: exp = 64 + 2 * m_presc + m_hiz;
      endcase
      chk($sformatf("R8 register readback sel%0d", k), int'(cap), exp);
      chk($sformatf("R8 oe during readback sel%0d", k), int'(oe), 1);
    end
    frame(8'hF2, 8, 0, 0, cap, oe);
    model_apply(8'hF2);
    sdi = 1'b1; wait_clk(4);
    chk("R8 sel9 echoes si", int'(sdo), 1);
    sdi = 1'b0; wait_clk(4);

    // R9 test high: select 9 has no effect
    test_n = 1'b1; wait_clk(5);
    chk("R9 oe off deselected", int'(sdo_oe), 0);
    good_write(8'h07, "R9 normal readback");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule